// File: doc/BRIEF.md
# Multi-Level Address Translation Table Walker

This block turns a 32-bit logical address into a physical address by reading translation descriptors from memory, one table level at a time. A control word sets the enable, the root selection, an initial shift of discarded top address bits and the index width of up to four levels (A to D). Two 64-bit root pointers are supplied: one always available and one reserved for supervisor accesses when the control word selects it. Each root pointer carries the first table's base, a descriptor type and a bound on the first-level index.

A request supplies the logical address, a write flag and a supervisor flag. The walker checks the root and the first-level bound, then issues one 32-bit read per level through a single-outstanding request/valid port. A walk may end early at any level on a page descriptor. In that case every logical-address bit below that level's index becomes page offset, so one entry can map a large block. The walk ends with a one-cycle done pulse. The pulse carries the physical address, the cache-inhibit flag of the final page descriptor and a two-bit fault code.

Top module: `ptw_walker`

## Requirements
- R1: With control bit 31 clear, a request completes with no memory read, with the physical address equal to the logical address, cache-inhibit low and fault code 0.
- R2: Control bits 19:16 give a count of top logical-address bits that are ignored. Below them, the A, B, C and D indices follow from the most significant bit downward, with widths taken from control bits 15:12, 11:8, 7:4 and 3:0. Each descriptor read goes to table_base + index*4.
- R3: The supervisor root pointer is used only when control bit 25 is set and the request is a supervisor request. Otherwise the CPU root pointer is used.
- R4: A root pointer whose type field (bits 33:32) is not 2 gives fault code 1 with no memory read. The first table's base is root bits 31:4 with the low four bits zero.
- R5: Root bits 62:48 hold a bound on the A index. With root bit 63 at 0, an index above the bound faults. With bit 63 at 1, an index below the bound faults. Either case gives fault code 2 with no memory read, and an index equal to the bound passes.
- R6: In a descriptor, type bits 1:0 equal to 0 (invalid) or 3 (unsupported long format) end the walk with fault code 1.
- R7: A descriptor of type 2 points to the next table at bits 31:4. If it is met at level D, or at a level whose next index width is zero, it ends the walk with fault code 1.
- R8: A descriptor of type 1 ends the walk at any level. The physical address takes its bits 31:8 above the offset and the logical-address bits below that level's index. A walk that ends at level n makes exactly n+1 reads.
- R9: Bit 6 of the final page descriptor is returned as the cache-inhibit output.
- R10: If bit 2 (write-protect) is set in any descriptor on the path, a write request gets fault code 3 and a read request completes normally.
- R11: An invalid or bound fault met on a path that already carried write-protect is reported as code 1 or 2, not 3.
- R12: Only one walk runs at a time. Busy is high from the cycle after acceptance until done. Done is a single-cycle pulse. Requests made while busy are ignored, and reset clears busy, done, the read request and the fault code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_laddr | input | 32 | Logical address |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is from supervisor mode |
| cfg_ctrl | input | 32 | Translation control word |
| cfg_crp | input | 64 | CPU root pointer |
| cfg_srp | input | 64 | Supervisor root pointer |
| mem_rd_req | output | 1 | Descriptor read request, held until valid |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor word |
| walk_busy | output | 1 | A walk is in progress |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_paddr | output | 32 | Physical address |
| walk_ci | output | 1 | Cache-inhibit of the final page |
| walk_fault | output | 2 | 0 none, 1 invalid, 2 bound, 3 write-protect |

## Verification
Two functions can fall in the same walk: a write-protect bit inherited from an upper table descriptor, and an invalid descriptor or a bound violation found at a later point. A write is sent through a protected table into an invalid leaf. The result must be fault code 1 after three reads, not code 3. A write through the same protected table into a valid page must give code 3, and a read of it must complete. The bound is tested on both sides and exactly at its value, and under both bound senses, so that a bound fault and a walk that proceeds are told apart by the read count.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W = 32;
    localparam int DESC_W = 32;
    localparam int ROOT_W = 64;
    localparam int LVL_N  = 4;
    localparam int LVL_W  = $clog2(LVL_N);
    localparam int WID_W  = 4;
    localparam int IDX_W  = (1 << WID_W) - 1;
    localparam int LIM_W  = 15;
    localparam int SH_W   = 7;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_LIMIT   = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        DT_INV   = 2'd0,
        DT_PAGE  = 2'd1,
        DT_TABLE = 2'd2,
        DT_LONG  = 2'd3
    } dtype_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ROOT  = 2'd1,
        S_FETCH = 2'd2
    } wstate_e;

    typedef struct packed {
        logic                         en;
        logic                         sre;
        logic [WID_W-1:0]             ishift;
        logic [LVL_N-1:0][WID_W-1:0]  tiw;   // element 0 is level A
    } ctrl_t;

    typedef struct packed {
        logic               lower;
        logic [LIM_W-1:0]   bound;
        dtype_e             dt;
        logic [ADDR_W-1:0]  base;
    } root_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] r);
        ctrl_t c;
        c.en     = r[31];
        c.sre    = r[25];
        c.ishift = r[19:16];
        c.tiw[0] = r[15:12];
        c.tiw[1] = r[11:8];
        c.tiw[2] = r[7:4];
        c.tiw[3] = r[3:0];
        return c;
    endfunction

    function automatic root_t decode_root(input logic [ROOT_W-1:0] r);
        root_t p;
        p.lower = r[63];
        p.bound = r[62:48];
        p.dt    = dtype_e'(r[33:32]);
        p.base  = {r[31:4], 4'b0000};
        return p;
    endfunction

endpackage

// File: rtl/ptw_level_split.sv
module ptw_level_split
    import ptw_pkg::*;
(
    input  ctrl_t              ctrl,
    input  logic [ADDR_W-1:0]  laddr,
    input  logic [LVL_W-1:0]   level,
    output logic [IDX_W-1:0]   index,
    output logic [ADDR_W-1:0]  off_mask,
    output logic               last
);
    logic [SH_W-1:0]   consumed;
    logic [SH_W-1:0]   total;
    logic [SH_W-1:0]   rem;
    logic [WID_W-1:0]  w;
    logic [ADDR_W-1:0] shifted;
    logic [LVL_W-1:0]  nxt;

    always_comb begin
        consumed = SH_W'(ctrl.ishift);
        for (int k = 0; k < LVL_N; k++) begin
            if (k < int'(level)) consumed = consumed + SH_W'(ctrl.tiw[k]);
        end
        w       = ctrl.tiw[level];
        shifted = (consumed >= SH_W'(ADDR_W)) ? '0 : (laddr << consumed);
        index   = (w == '0) ? '0 : IDX_W'(shifted >> (SH_W'(ADDR_W) - SH_W'(w)));
        total   = consumed + SH_W'(w);
        rem     = (total >= SH_W'(ADDR_W)) ? '0 : SH_W'(ADDR_W) - total;
        if (rem >= SH_W'(ADDR_W)) off_mask = '1;
        else                      off_mask = (ADDR_W'(1) << rem) - ADDR_W'(1);
        nxt  = level + LVL_W'(1);
        last = (int'(level) == LVL_N - 1) || (ctrl.tiw[nxt] == '0);
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0]  desc,
    output dtype_e             dt,
    output logic [ADDR_W-1:0]  next_base,
    output logic [ADDR_W-1:0]  page_base,
    output logic               wp,
    output logic               ci
);
    assign dt        = dtype_e'(desc[1:0]);
    assign next_base = {desc[31:4], 4'b0000};
    assign page_base = {desc[31:8], 8'h00};
    assign wp        = desc[2];
    assign ci        = desc[6];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [31:0]        req_laddr,
    input  logic               req_write,
    input  logic               req_super,
    input  logic [31:0]        cfg_ctrl,
    input  logic [63:0]        cfg_crp,
    input  logic [63:0]        cfg_srp,
    output logic               mem_rd_req,
    output logic [31:0]        mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [31:0]        mem_rd_data,
    output logic               walk_busy,
    output logic               walk_done,
    output logic [31:0]        walk_paddr,
    output logic               walk_ci,
    output logic [1:0]         walk_fault
);
    wstate_e            state;
    ctrl_t              ctl_q;
    root_t              rp_q;
    logic [ADDR_W-1:0]  la_q;
    logic               wr_q;
    logic [LVL_W-1:0]   level_q;
    logic [ADDR_W-1:0]  base_q;
    logic               wp_q;

    logic               done_q;
    logic [ADDR_W-1:0]  pa_q;
    logic               ci_q;
    fault_e             flt_q;

    // Index extraction for the level being walked
    logic [IDX_W-1:0]   idx;
    logic [ADDR_W-1:0]  off_mask;
    logic               lvl_last;

    ptw_level_split u_split (
        .ctrl     (ctl_q),
        .laddr    (la_q),
        .level    (level_q),
        .index    (idx),
        .off_mask (off_mask),
        .last     (lvl_last)
    );

    dtype_e             d_dt;
    logic [ADDR_W-1:0]  d_next;
    logic [ADDR_W-1:0]  d_page;
    logic               d_wp;
    logic               d_ci;

    ptw_desc_decode u_dec (
        .desc      (mem_rd_data),
        .dt        (d_dt),
        .next_base (d_next),
        .page_base (d_page),
        .wp        (d_wp),
        .ci        (d_ci)
    );

    logic limit_hit;
    assign limit_hit = rp_q.lower ? (idx < rp_q.bound) : (idx > rp_q.bound);

    // Next-step decision
    logic               fin;
    logic [ADDR_W-1:0]  fin_pa;
    logic               fin_ci;
    fault_e             fin_flt;
    logic               go_fetch;
    logic               descend;

    always_comb begin
        fin      = 1'b0;
        fin_pa   = la_q;
        fin_ci   = 1'b0;
        fin_flt  = FLT_NONE;
        go_fetch = 1'b0;
        descend  = 1'b0;
        unique case (state)
            S_ROOT: begin
                if (!ctl_q.en) begin
                    fin = 1'b1;
                end else if (rp_q.dt != DT_TABLE || ctl_q.tiw[0] == '0) begin
                    fin     = 1'b1;
                    fin_flt = FLT_INVALID;
                end else if (limit_hit) begin
                    fin     = 1'b1;
                    fin_flt = FLT_LIMIT;
                end else begin
                    go_fetch = 1'b1;
                end
            end
            S_FETCH: begin
                if (mem_rd_valid) begin
                    unique case (d_dt)
                        DT_TABLE: begin
                            if (lvl_last) begin
                                fin     = 1'b1;
                                fin_flt = FLT_INVALID;
                            end else begin
                                descend = 1'b1;
                            end
                        end
                        DT_PAGE: begin
                            fin    = 1'b1;
                            fin_pa = (d_page & ~off_mask) | (la_q & off_mask);
                            fin_ci = d_ci;
                            if (wr_q && (wp_q || d_wp)) fin_flt = FLT_WPROT;
                        end
                        default: begin
                            fin     = 1'b1;
                            fin_flt = FLT_INVALID;
                        end
                    endcase
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            ctl_q   <= '0;
            rp_q    <= '0;
            la_q    <= '0;
            wr_q    <= 1'b0;
            level_q <= '0;
            base_q  <= '0;
            wp_q    <= 1'b0;
            done_q  <= 1'b0;
            pa_q    <= '0;
            ci_q    <= 1'b0;
            flt_q   <= FLT_NONE;
        end else begin
            done_q <= 1'b0;
            if (state == S_IDLE) begin
                if (req_valid) begin
                    la_q    <= req_laddr;
                    wr_q    <= req_write;
                    ctl_q   <= decode_ctrl(cfg_ctrl);
                    rp_q    <= (cfg_ctrl[25] && req_super) ? decode_root(cfg_srp)
                                                           : decode_root(cfg_crp);
                    level_q <= '0;
                    wp_q    <= 1'b0;
                    state   <= S_ROOT;
                end
            end else if (fin) begin
                done_q <= 1'b1;
                pa_q   <= fin_pa;
                ci_q   <= fin_ci;
                flt_q  <= fin_flt;
                state  <= S_IDLE;
            end else if (go_fetch) begin
                base_q <= rp_q.base;
                state  <= S_FETCH;
            end else if (descend) begin
                base_q  <= d_next;
                wp_q    <= wp_q | d_wp;
                level_q <= level_q + LVL_W'(1);
            end
        end
    end

    assign mem_rd_req  = (state == S_FETCH);
    assign mem_rd_addr = base_q + (ADDR_W'(idx) << 2);
    assign walk_busy   = (state != S_IDLE);
    assign walk_done   = done_q;
    assign walk_paddr  = pa_q;
    assign walk_ci     = ci_q;
    assign walk_fault  = flt_q;

    AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (walk_done && !ctl_q.en) |-> (walk_paddr == la_q && !walk_ci && walk_fault == 2'd0))
        else $error("bypass result differs from logical address"); // R1
    AST_NO_READ_BYPASS: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> ctl_q.en)
        else $error("descriptor read while translation disabled"); // R1
    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)))
        else $error("read request dropped or moved before valid"); // R2
    AST_LIMIT_FROM_ROOT: assert property (@(posedge clk) disable iff (rst)
        (walk_done && walk_fault == 2'd2) |-> ($past(state) == S_ROOT))
        else $error("bound fault after a descriptor read"); // R5
    AST_WP_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (walk_done && walk_fault == 2'd3) |-> wr_q)
        else $error("write-protect fault on a read"); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done)
        else $error("done longer than one cycle"); // R12
endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    import ptw_pkg::*;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic [31:0] cfg_ctrl  = '0;
    logic [63:0] cfg_crp   = '0;
    logic [63:0] cfg_srp   = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        walk_busy;
    logic        walk_done;
    logic [31:0] walk_paddr;
    logic        walk_ci;
    logic [1:0]  walk_fault;

    ptw_walker dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_laddr(req_laddr),
        .req_write(req_write), .req_super(req_super),
        .cfg_ctrl(cfg_ctrl), .cfg_crp(cfg_crp), .cfg_srp(cfg_srp),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .walk_busy(walk_busy), .walk_done(walk_done),
        .walk_paddr(walk_paddr), .walk_ci(walk_ci), .walk_fault(walk_fault)
    );

    // Descriptor memory: 256 words, one-cycle read latency
    logic [31:0] mem [256];
    int unsigned fetch_cnt;

    always @(posedge clk) begin
        if (rst) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
            fetch_cnt    <= 0;
        end else begin
            mem_rd_valid <= mem_rd_req && !mem_rd_valid;
            mem_rd_data  <= mem[mem_rd_addr[9:2]];
            if (mem_rd_req && !mem_rd_valid) fetch_cnt <= fetch_cnt + 1;
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] la, input logic wr, input logic sup,
                        output logic [31:0] pa, output logic ci,
                        output logic [1:0] flt, output int nf);
        int unsigned f0;
        bit hung;
        @(negedge clk);
        f0 = fetch_cnt;
        req_valid = 1'b1; req_laddr = la; req_write = wr; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        hung = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (walk_done) begin hung = 1'b0; break; end
            @(negedge clk);
        end
        if (hung) begin
            checks++; errors++;
            $display("FAIL R12 walk timeout actual=busy expected=done");
        end
        pa = walk_paddr; ci = walk_ci; flt = walk_fault;
        nf = int'(fetch_cnt - f0);
    endtask

    typedef struct packed {
        logic [31:0] la;
        logic        wr;
        logic        sup;
        logic [31:0] pa;
        logic        ci;
        logic [1:0]  flt;
        logic [3:0]  nf;
    } vec_t;

    // ctrl 0x82C84440: enable, supervisor root on, 8 ignored bits, widths 4/4/4/0
    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{32'hFF1ABCDE, 1'b0, 1'b0, 32'h123ABCDE, 1'b0, 2'd0, 4'd1}, // R2 R8 level-A page, top bits ignored
        '{32'h00012345, 1'b0, 1'b0, 32'h45602345, 1'b0, 2'd0, 4'd2}, // R8 level-B page
        '{32'h00001789, 1'b0, 1'b0, 32'h0F0F1789, 1'b1, 2'd0, 4'd3}, // R9 level-C page with CI
        '{32'h00000ABC, 1'b0, 1'b0, 32'hABCDEABC, 1'b0, 2'd0, 4'd3}, // R7 R8 full walk
        '{32'h00202222, 1'b0, 1'b0, 32'h0,        1'b0, 2'd1, 4'd1}, // R6 type 0
        '{32'h00300000, 1'b0, 1'b0, 32'h0,        1'b0, 2'd1, 4'd1}, // R6 type 3
        '{32'h00A00000, 1'b0, 1'b0, 32'h0,        1'b0, 2'd2, 4'd0}, // R5 above upper bound
        '{32'h00900000, 1'b0, 1'b0, 32'h0,        1'b0, 2'd1, 4'd1}, // R5 equal bound passes
        '{32'h00022000, 1'b1, 1'b0, 32'h0,        1'b0, 2'd3, 4'd2}, // R10 write to WP page
        '{32'h00022000, 1'b0, 1'b0, 32'h30002000, 1'b0, 2'd0, 4'd2}, // R10 read of WP page
        '{32'h00401234, 1'b1, 1'b0, 32'h0,        1'b0, 2'd3, 4'd3}, // R10 WP inherited from table
        '{32'h00401234, 1'b0, 1'b0, 32'h0F0F1234, 1'b1, 2'd0, 4'd3}, // R10 read via WP table
        '{32'h00512345, 1'b0, 1'b0, 32'h77012345, 1'b1, 2'd0, 4'd1}, // R9 level-A page with CI
        '{32'h00002000, 1'b0, 1'b0, 32'h0,        1'b0, 2'd1, 4'd3}, // R7 table at last level
        '{32'h00012345, 1'b1, 1'b0, 32'h45602345, 1'b0, 2'd0, 4'd2}, // R10 write, no WP
        '{32'h00212345, 1'b0, 1'b1, 32'h88812345, 1'b0, 2'd0, 4'd1}, // R3 supervisor root
        '{32'h00112345, 1'b0, 1'b1, 32'h0,        1'b0, 2'd2, 4'd0}, // R5 below lower bound
        '{32'h00312345, 1'b0, 1'b1, 32'h0,        1'b0, 2'd1, 4'd1}, // R3 supervisor table entry
        '{32'h00403000, 1'b1, 1'b0, 32'h0,        1'b0, 2'd1, 4'd3}  // R11 invalid beats WP
    };

    localparam logic [31:0] CTRL_ON = 32'h82C8_4440;
    localparam logic [63:0] CRP_OK  = 64'h0009_0002_0000_0000;
    localparam logic [63:0] SRP_OK  = 64'h8002_0002_0000_0100;

    initial begin
        logic [31:0] pa;
        logic        ci;
        logic [1:0]  flt;
        int          nf;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[0]  = 32'h0000004A; mem[1]  = 32'h12300019; mem[3]  = 32'h00000003;
        mem[4]  = 32'h0000004E; mem[5]  = 32'h77000059;
        mem[16] = 32'h0000008A; mem[17] = 32'h45600019; mem[18] = 32'h3000001D;
        mem[32] = 32'hABCDE019; mem[33] = 32'h0F0F1059; mem[34] = 32'h0000004A;
        mem[66] = 32'h88800019;

        repeat (3) @(negedge clk);
        check("R12", "reset busy",  32'(walk_busy),  32'd0);
        check("R12", "reset done",  32'(walk_done),  32'd0);
        check("R12", "reset rdreq", 32'(mem_rd_req), 32'd0);
        check("R12", "reset fault", 32'(walk_fault), 32'd0);
        rst = 1'b0;

        cfg_ctrl = CTRL_ON; cfg_crp = CRP_OK; cfg_srp = SRP_OK;
        for (int v = 0; v < NV; v++) begin
            walk(VECS[v].la, VECS[v].wr, VECS[v].sup, pa, ci, flt, nf);
            check("R2-R11 vector", $sformatf("v%0d fault", v), 32'(flt), 32'(VECS[v].flt));
            check("R8 vector", $sformatf("v%0d reads", v), 32'(nf), 32'(VECS[v].nf));
            if (VECS[v].flt == 2'd0) begin
                check("R8 vector", $sformatf("v%0d paddr", v), pa, VECS[v].pa);
                check("R9 vector", $sformatf("v%0d ci", v), 32'(ci), 32'(VECS[v].ci));
            end
        end

        // R1: translation disabled
        cfg_ctrl = 32'h02C8_4440;
        walk(32'hDEADBEEF, 1'b1, 1'b0, pa, ci, flt, nf);
        check("R1", "bypass paddr", pa, 32'hDEADBEEF);
        check("R1", "bypass fault", 32'(flt), 32'd0);
        check("R1", "bypass ci", 32'(ci), 32'd0);
        check("R1", "bypass reads", 32'(nf), 32'd0);

        // R3: supervisor-root enable clear -> CPU root for supervisor
        cfg_ctrl = 32'h80C8_4440;
        walk(32'h00012345, 1'b0, 1'b1, pa, ci, flt, nf);
        check("R3", "shared root paddr", pa, 32'h45602345);
        check("R3", "shared root reads", 32'(nf), 32'd2);

        // R4: root type not table
        cfg_ctrl = CTRL_ON; cfg_crp = 64'h0009_0001_0000_0000;
        walk(32'h00000ABC, 1'b0, 1'b0, pa, ci, flt, nf);
        check("R4", "bad root fault", 32'(flt), 32'd1);
        check("R4", "bad root reads", 32'(nf), 32'd0);
        cfg_crp = CRP_OK;

        // R12: second request while busy is ignored; done is one cycle
        @(negedge clk);
        req_valid = 1'b1; req_laddr = 32'h00000ABC; req_write = 1'b0; req_super = 1'b0;
        @(negedge clk);
        req_laddr = 32'h00012345;
        check("R12", "busy after accept", 32'(walk_busy), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (walk_done) break;
            @(negedge clk);
        end
        check("R12", "overlap done", 32'(walk_done), 32'd1);
        check("R12", "overlap paddr", walk_paddr, 32'hABCDEABC);
        @(negedge clk);
        check("R12", "done pulse width", 32'(walk_done), 32'd0);
        check("R12", "idle after done", 32'(walk_busy), 32'd0);
        begin
            bit extra;
            extra = 1'b0;
            for (int i = 0; i < 12; i++) begin
                if (walk_done || walk_busy) extra = 1'b1;
                @(negedge clk);
            end
            check("R12", "ignored request stayed idle", 32'(extra), 32'd0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule